// File: doc/BRIEF.md
# Compare-Capture Timer Channel

This block is one 16-bit counter/timer channel for a register-mapped peripheral. The counter counts one of two sources, chosen by a control bit. The first is the internal clock divided by a selectable power of two. The second is the rising edges of a synchronized external event input. When the counter reaches its terminal value, it reloads from a load register or, for true modulo counting, from either compare preload register.

Two compare registers watch the count. A match drives an output flag by a per-compare action code and sets a status bit that can raise an interrupt. If enabled, a match also copies the preload value into the compare register that matched. Rising edges on a capture input push the count into a two-entry first-in first-out queue. A hold register snapshots the count on a strobe from a cascaded neighbour's read, so that wide values read back coherently.

Software reaches the channel through a word-wide write/read port. Register addresses: 0 count, 1 load, 2 hold (read only), 3 capture queue head (read pops), 4 compare 1, 5 compare 2, 6 preload 1, 7 preload 2, 8 control, 9 status, 10 interrupt enable. Other addresses read as zero.

Top module: `cct_channel`

## Requirements
- R1: After reset the count, every register, the status bits, the output flag, the interrupt and the capture queue level are all zero, and reading an empty queue (address 3) returns zero.
- R2: With control bit 4 (count enable) set and bit 3 clear, the count rises by one every 2^s clock cycles, where s is control bits [2:0]. With bit 4 clear, the count holds.
- R3: With control bits 3 and 4 set, the count rises by exactly one for each rising edge of `evtIn`, after a two-stage synchronizer.
- R4: The terminal value is 0xFFFF, or compare 1 when control bit 5 is set. The tick that leaves the terminal value loads the source chosen by control bits [7:6]: 01 preload 1, 10 preload 2, otherwise the load register.
- R5: A `holdSnap` pulse copies the current count into the hold register (address 2), which keeps that value until the next pulse.
- R6: Each synchronized rising edge of `capIn` pushes the count into the queue. Reading address 3 returns the oldest entry and removes it. Status bits [5:4] give the queue level.
- R7: A capture that arrives while two entries are held is discarded and sets sticky status bit 3. Every capture edge sets status bit 2.
- R8: A compare match occurs on a count tick taken while the count equals the compare register. It sets status bit 0 (compare 1) or bit 1 (compare 2) and applies that compare's flag action (control [9:8] for compare 1, [11:10] for compare 2): 00 none, 01 set, 10 clear, 11 toggle. Status bit 6 reads back `outFlag`.
- R9: When both compares match on the same tick, only the compare 1 action is applied.
- R10: With control bit 12 (or 13) set, a match on compare 1 (or 2) loads that compare register from its preload register. With the bit clear, the compare register is kept.
- R11: Status bits [3:0] clear when 1 is written to them, and a set event wins over a clear in the same cycle. `irq` is the OR of the status bits [3:0] whose enable bit (address 10, bits [3:0]) is set.
- R12: A write to address 0 loads the count directly and overrides a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (pops the capture queue at address 3) |
| addr | input | 4 | Register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, combinational from `addr` |
| evtIn | input | 1 | External count event input, asynchronous |
| capIn | input | 1 | Capture trigger input, asynchronous |
| holdSnap | input | 1 | Snapshot strobe from a cascaded neighbour's read |
| outFlag | output | 1 | Compare-driven output flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench looks for the off-by-one hazards around the terminal value. It checks both the wrap at 0xFFFF and the compare-bounded modulo reload from each preload. A design that reloads one tick early or late, or picks the wrong source, shows the wrong count after two event steps. It drives simultaneous matches on both compares with opposing actions: a design with the priority reversed leaves the flag in the wrong state. Random capture and pop sequences against a queue model catch a design that returns the newest entry, overwrites on overflow, or loses the sticky overflow bit. A counter write on a running clock confirms that the write beats the increment.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 3;
  localparam int CTRL_W = 14;
  localparam int STAT_W = 4;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_COUNT  = 4'd0,
    A_RELOAD = 4'd1,
    A_HOLD   = 4'd2,
    A_CAPT   = 4'd3,
    A_CMP1   = 4'd4,
    A_CMP2   = 4'd5,
    A_PRE1   = 4'd6,
    A_PRE2   = 4'd7,
    A_CTRL   = 4'd8,
    A_STATUS = 4'd9,
    A_INTEN  = 4'd10
  } regAddrE;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } flagActE;

  typedef enum logic [1:0] {
    RLD_LOAD = 2'b00,
    RLD_PRE1 = 2'b01,
    RLD_PRE2 = 2'b10,
    RLD_ALT  = 2'b11
  } rldSelE;

  // Decoded control word
  typedef struct packed {
    logic [PRE_W-1:0] presSel;
    logic             extSrc;
    logic             cntEn;
    logic             lenMode;
    rldSelE           reloadSel;
    flagActE          act1;
    flagActE          act2;
    logic             pl1;
    logic             pl2;
  } cfgT;

  // Strobes from control to datapath
  typedef struct packed {
    logic             wrCount;
    logic             wrReload;
    logic             wrCmp1;
    logic             wrCmp2;
    logic             wrPre1;
    logic             wrPre2;
    logic             popCap;
    logic             snapHold;
    logic [CNT_W-1:0] wdata;
  } strobeT;
endpackage

// File: rtl/cct_sync.sv
module cct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sh <= '0;
    else       sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/cct_capq.sv
module cct_capq #(
  parameter int W     = 16,
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [W-1:0]     pushData,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [LVL_W-1:0] level,
  output logic             ovf
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             doPop, doPush;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign doPop  = pop && (level != '0);
  assign doPush = push && ((level != LVL_W'(DEPTH)) || doPop);
  assign ovf    = push && !doPush;
  assign head   = (level != '0) ? mem[rdPtr] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      level <= level + LVL_W'(doPush) - LVL_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end
endmodule

// File: rtl/cct_datapath.sv
module cct_datapath
  import cct_pkg::*;
#(
  parameter int CAPQ_DEPTH  = 2,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W = $clog2(CAPQ_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strb,
  input  cfgT              cfg,
  input  logic             evtIn,
  input  logic             capIn,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] holdVal,
  output logic [CNT_W-1:0] cmp1Val,
  output logic [CNT_W-1:0] cmp2Val,
  output logic [CNT_W-1:0] pre1Val,
  output logic [CNT_W-1:0] pre2Val,
  output logic [CNT_W-1:0] capHead,
  output logic [LVL_W-1:0] capLevel,
  output logic             capPush,
  output logic             capOvf,
  output logic             match1,
  output logic             match2,
  output logic             outFlag
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] divCnt, divMask;
  logic             intTick, evtRise, tick, atTerm;
  logic [CNT_W-1:0] rldSrc;

  // Prescaler: free-running divider, tick when low presSel bits all ones
  always_comb begin
    for (int i = 0; i < DIV_W; i++) divMask[i] = (i < int'(cfg.presSel));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + DIV_W'(1);
  end

  assign intTick = ((divCnt & divMask) == divMask);

  cct_sync #(.STAGES(SYNC_STAGES)) u_evtSync (
    .clk (clk), .rstN(rstN), .din(evtIn), .rise(evtRise)
  );

  cct_sync #(.STAGES(SYNC_STAGES)) u_capSync (
    .clk (clk), .rstN(rstN), .din(capIn), .rise(capPush)
  );

  assign tick   = cfg.cntEn & (cfg.extSrc ? evtRise : intTick);
  assign atTerm = cfg.lenMode ? (cntVal == cmp1Val) : (cntVal == '1);
  assign match1 = tick & (cntVal == cmp1Val);
  assign match2 = tick & (cntVal == cmp2Val);

  always_comb begin
    unique case (cfg.reloadSel)
      RLD_PRE1: rldSrc = pre1Val;
      RLD_PRE2: rldSrc = pre2Val;
      default:  rldSrc = reloadVal;
    endcase
  end

  function automatic logic applyAct(input flagActE act, input logic cur);
    unique case (act)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

  // Counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cntVal <= '0;
    else if (strb.wrCount) cntVal <= strb.wdata;
    else if (tick)         cntVal <= atTerm ? rldSrc : cntVal + CNT_W'(1);
  end

  // Load, preload and hold registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadVal <= '0;
      pre1Val   <= '0;
      pre2Val   <= '0;
      holdVal   <= '0;
    end else begin
      if (strb.wrReload) reloadVal <= strb.wdata;
      if (strb.wrPre1)   pre1Val   <= strb.wdata;
      if (strb.wrPre2)   pre2Val   <= strb.wdata;
      if (strb.snapHold) holdVal   <= cntVal;
    end
  end

  // Compare registers with match-time preload
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmp1Val <= '0;
      cmp2Val <= '0;
    end else begin
      if (strb.wrCmp1)            cmp1Val <= strb.wdata;
      else if (match1 && cfg.pl1) cmp1Val <= pre1Val;
      if (strb.wrCmp2)            cmp2Val <= strb.wdata;
      else if (match2 && cfg.pl2) cmp2Val <= pre2Val;
    end
  end

  // Output flag, compare 1 wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       outFlag <= 1'b0;
    else if (match1) outFlag <= applyAct(cfg.act1, outFlag);
    else if (match2) outFlag <= applyAct(cfg.act2, outFlag);
  end

  cct_capq #(.W(CNT_W), .DEPTH(CAPQ_DEPTH)) u_capq (
    .clk     (clk),
    .rstN    (rstN),
    .push    (capPush),
    .pushData(cntVal),
    .pop     (strb.popCap),
    .head    (capHead),
    .level   (capLevel),
    .ovf     (capOvf)
  );
endmodule

// File: rtl/cct_ctrl.sv
module cct_ctrl
  import cct_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              holdSnap,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  reloadVal,
  input  logic [CNT_W-1:0]  holdVal,
  input  logic [CNT_W-1:0]  cmp1Val,
  input  logic [CNT_W-1:0]  cmp2Val,
  input  logic [CNT_W-1:0]  pre1Val,
  input  logic [CNT_W-1:0]  pre2Val,
  input  logic [CNT_W-1:0]  capHead,
  input  logic [LVL_W-1:0]  capLevel,
  input  logic              capPush,
  input  logic              capOvf,
  input  logic              match1,
  input  logic              match2,
  input  logic              outFlag,
  output strobeT            strb,
  output cfgT               cfg,
  output logic [STAT_W-1:0] statusBits,
  output logic [CNT_W-1:0]  rdData,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrlReg;
  logic [STAT_W-1:0] intEn, statSet, statClr;

  function automatic logic wrHit(input regAddrE a);
    return wrEn && (addr == a);
  endfunction

  always_comb begin
    strb.wrCount  = wrHit(A_COUNT);
    strb.wrReload = wrHit(A_RELOAD);
    strb.wrCmp1   = wrHit(A_CMP1);
    strb.wrCmp2   = wrHit(A_CMP2);
    strb.wrPre1   = wrHit(A_PRE1);
    strb.wrPre2   = wrHit(A_PRE2);
    strb.popCap   = rdEn && (addr == A_CAPT);
    strb.snapHold = holdSnap;
    strb.wdata    = wrData;
  end

  always_comb begin
    cfg.presSel   = ctrlReg[PRE_W-1:0];
    cfg.extSrc    = ctrlReg[3];
    cfg.cntEn     = ctrlReg[4];
    cfg.lenMode   = ctrlReg[5];
    cfg.reloadSel = rldSelE'(ctrlReg[7:6]);
    cfg.act1      = flagActE'(ctrlReg[9:8]);
    cfg.act2      = flagActE'(ctrlReg[11:10]);
    cfg.pl1       = ctrlReg[12];
    cfg.pl2       = ctrlReg[13];
  end

  assign statSet = {capOvf, capPush, match2, match1};
  assign statClr = wrHit(A_STATUS) ? wrData[STAT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      intEn      <= '0;
      statusBits <= '0;
    end else begin
      if (wrHit(A_CTRL))  ctrlReg <= wrData[CTRL_W-1:0];
      if (wrHit(A_INTEN)) intEn   <= wrData[STAT_W-1:0];
      statusBits <= (statusBits & ~statClr) | statSet;
    end
  end

  assign irq = |(statusBits & intEn);

  always_comb begin
    unique case (addr)
      A_COUNT:  rdData = cntVal;
      A_RELOAD: rdData = reloadVal;
      A_HOLD:   rdData = holdVal;
      A_CAPT:   rdData = capHead;
      A_CMP1:   rdData = cmp1Val;
      A_CMP2:   rdData = cmp2Val;
      A_PRE1:   rdData = pre1Val;
      A_PRE2:   rdData = pre2Val;
      A_CTRL:   rdData = CNT_W'(ctrlReg);
      A_STATUS: rdData = CNT_W'({outFlag, capLevel, statusBits});
      A_INTEN:  rdData = CNT_W'(intEn);
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/cct_channel.sv
module cct_channel
  import cct_pkg::*;
#(
  parameter int CAPQ_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [3:0]  addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic        evtIn,
  input  logic        capIn,
  input  logic        holdSnap,
  output logic        outFlag,
  output logic        irq
);
  localparam int LVL_W = $clog2(CAPQ_DEPTH + 1);

  strobeT            strb;
  cfgT               cfg;
  logic [CNT_W-1:0]  cntVal, reloadVal, holdVal, cmp1Val, cmp2Val;
  logic [CNT_W-1:0]  pre1Val, pre2Val, capHead;
  logic [LVL_W-1:0]  capLevel;
  logic              capPush, capOvf, match1, match2;
  logic [STAT_W-1:0] statusBits;

  cct_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .addr      (addr),
    .wrData    (wrData),
    .holdSnap  (holdSnap),
    .cntVal    (cntVal),
    .reloadVal (reloadVal),
    .holdVal   (holdVal),
    .cmp1Val   (cmp1Val),
    .cmp2Val   (cmp2Val),
    .pre1Val   (pre1Val),
    .pre2Val   (pre2Val),
    .capHead   (capHead),
    .capLevel  (capLevel),
    .capPush   (capPush),
    .capOvf    (capOvf),
    .match1    (match1),
    .match2    (match2),
    .outFlag   (outFlag),
    .strb      (strb),
    .cfg       (cfg),
    .statusBits(statusBits),
    .rdData    (rdData),
    .irq       (irq)
  );

  cct_datapath #(.CAPQ_DEPTH(CAPQ_DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfg      (cfg),
    .evtIn    (evtIn),
    .capIn    (capIn),
    .cntVal   (cntVal),
    .reloadVal(reloadVal),
    .holdVal  (holdVal),
    .cmp1Val  (cmp1Val),
    .cmp2Val  (cmp2Val),
    .pre1Val  (pre1Val),
    .pre2Val  (pre2Val),
    .capHead  (capHead),
    .capLevel (capLevel),
    .capPush  (capPush),
    .capOvf   (capOvf),
    .match1   (match1),
    .match2   (match2),
    .outFlag  (outFlag)
  );
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int DEPTH = 2,
  parameter int LVL_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntEn,
  input logic             wrCount,
  input logic [15:0]      wrData,
  input logic [15:0]      cntVal,
  input logic             snapHold,
  input logic [15:0]      holdVal,
  input logic [LVL_W-1:0] capLevel,
  input logic             capPush,
  input logic             capPop,
  input logic [3:0]       statusBits,
  input logic             wrStatus,
  input logic             match1,
  input logic             match2,
  input logic [1:0]       act1,
  input logic             pl1,
  input logic             wrCmp1,
  input logic [15:0]      cmp1Val,
  input logic [15:0]      pre1Val,
  input logic             outFlag
);
  assert_count_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn && !wrCount |=> $stable(cntVal));

  assert_hold_snap_R5: assert property (@(posedge clk) disable iff (!rstN)
    snapHold |=> holdVal == $past(cntVal));

  assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    capLevel <= LVL_W'(DEPTH));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    capPush && capLevel == LVL_W'(DEPTH) && !capPop
      |=> statusBits[3] && capLevel == LVL_W'(DEPTH));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    match1 && act1 == 2'b01 |=> outFlag);

  assert_cmp1_prio_R9: assert property (@(posedge clk) disable iff (!rstN)
    match1 && match2 && act1 == 2'b10 |=> !outFlag);

  assert_preload_R10: assert property (@(posedge clk) disable iff (!rstN)
    match1 && pl1 && !wrCmp1 |=> cmp1Val == $past(pre1Val));

  assert_w1c_R11: assert property (@(posedge clk) disable iff (!rstN)
    wrStatus && wrData[0] && !match1 |=> !statusBits[0]);

  assert_count_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    wrCount |=> cntVal == $past(wrData));
endmodule

bind cct_channel cct_checker #(.DEPTH(CAPQ_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cntEn     (cfg.cntEn),
  .wrCount   (strb.wrCount),
  .wrData    (wrData),
  .cntVal    (cntVal),
  .snapHold  (strb.snapHold),
  .holdVal   (holdVal),
  .capLevel  (capLevel),
  .capPush   (capPush),
  .capPop    (strb.popCap),
  .statusBits(statusBits),
  .wrStatus  (wrEn && addr == 4'd9),
  .match1    (match1),
  .match2    (match2),
  .act1      (cfg.act1),
  .pl1       (cfg.pl1),
  .wrCmp1    (strb.wrCmp1),
  .cmp1Val   (cmp1Val),
  .pre1Val   (pre1Val),
  .outFlag   (outFlag)
);

// File: tb/sim_cct_channel.sv
module sim_cct_channel;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] C_EXT = 16'h0018;   // extSrc | cntEn

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        evtIn = 1'b0, capIn = 1'b0, holdSnap = 1'b0;
  logic        outFlag, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  cct_channel u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evtIn(evtIn), .capIn(capIn),
    .holdSnap(holdSnap), .outFlag(outFlag), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1; #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdData;
  endtask

  task automatic evtStep();
    @(negedge clk); evtIn = 1'b1;
    repeat (2) @(negedge clk);
    evtIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic capPulse();
    @(negedge clk); capIn = 1'b1;
    repeat (2) @(negedge clk);
    capIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Expected ticks over n cycles at prescale s (n a multiple of 2^s)
  function automatic logic [15:0] expTicks(input int n, input int s);
    return 16'(n >> s);
  endfunction

  function automatic logic actOn(input logic [1:0] a, input logic cur);
    case (a)
      2'b01:   return 1'b1;
      2'b10:   return 1'b0;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, a0, a1;
    logic [15:0] q[$];
    logic expOvf, expFlag;
    int unsigned seed;
    seed = $urandom(32'h00C0FFEE);

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int i = 0; i < 11; i++) begin
      peek(4'(i), d);
      chk($sformatf("R1 reg %0d", i), d, 16'h0);
    end
    chk("R1 outFlag", {15'b0, outFlag}, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    rd(4'd3, d);
    chk("R1 empty queue read", d, 16'h0);

    // R12: write overrides a running tick
    wr(4'd8, 16'h0010);
    wr(4'd0, 16'h1234);
    addr = 4'd0; #1;
    chk("R12 direct load", rdData, 16'h1234);
    peek(4'd0, d);
    chk("R12 then counts", d, 16'h1235);

    // R2: prescaler rates and disable
    for (int s = 0; s < 4; s++) begin
      wr(4'd8, 16'h0000);
      wr(4'd0, 16'h0000);
      wr(4'd8, 16'h0010 | 16'(s));
      peek(4'd0, a0);
      repeat (16) @(negedge clk);
      #1 a1 = rdData;
      chk($sformatf("R2 prescale %0d", s), a1 - a0, expTicks(16, s));
    end
    wr(4'd8, 16'h0000);
    peek(4'd0, a0);
    repeat (16) @(negedge clk);
    #1 a1 = rdData;
    chk("R2 disabled holds", a1 - a0, 16'h0);

    // R3: external events
    wr(4'd0, 16'h0000);
    wr(4'd5, 16'h7777);
    wr(4'd8, C_EXT);
    for (int i = 0; i < 5; i++) evtStep();
    peek(4'd0, d);
    chk("R3 five events", d, 16'd5);

    // R4: terminal at all-ones, reload from load register
    wr(4'd1, 16'h0100);
    wr(4'd0, 16'hFFFE);
    evtStep(); peek(4'd0, d);
    chk("R4 reach FFFF", d, 16'hFFFF);
    evtStep(); peek(4'd0, d);
    chk("R4 wrap to load", d, 16'h0100);
    // R4: compare-bounded modulo from preload 1
    wr(4'd4, 16'd5);
    wr(4'd6, 16'd2);
    wr(4'd7, 16'd7);
    wr(4'd8, C_EXT | 16'h0060);
    wr(4'd0, 16'd4);
    evtStep(); evtStep(); peek(4'd0, d);
    chk("R4 modulo preload 1", d, 16'd2);
    wr(4'd8, C_EXT | 16'h00A0);
    wr(4'd0, 16'd4);
    evtStep(); evtStep(); peek(4'd0, d);
    chk("R4 modulo preload 2", d, 16'd7);

    // R8: flag actions on compare 1
    expFlag = outFlag;
    wr(4'd4, 16'd3);
    for (int k = 0; k < 6; k++) begin
      logic [1:0] act;
      act = (k < 4) ? 2'(k) : ((k == 4) ? 2'b11 : 2'b10);
      wr(4'd8, C_EXT | {6'b0, act, 8'h00});
      wr(4'd0, 16'd3);
      evtStep();
      expFlag = actOn(act, expFlag);
      chk($sformatf("R8 action %0d", act), {15'b0, outFlag}, {15'b0, expFlag});
    end
    peek(4'd9, d);
    chk("R8 status bit0 and flag readback", {9'b0, d[6], 5'b0, d[0]}, {9'b0, expFlag, 6'b1});

    // R9: both match, compare 1 wins
    wr(4'd9, 16'h000F);
    wr(4'd4, 16'd10);
    wr(4'd5, 16'd10);
    wr(4'd8, C_EXT | 16'h0900);
    wr(4'd0, 16'd10);
    evtStep();
    chk("R9 set beats clear", {15'b0, outFlag}, 16'h1);
    peek(4'd9, d);
    chk("R9 both status bits", {14'b0, d[1:0]}, 16'h3);
    wr(4'd8, C_EXT | 16'h0600);
    wr(4'd0, 16'd10);
    evtStep();
    chk("R9 clear beats set", {15'b0, outFlag}, 16'h0);

    // R10: preload on compare 1 only
    wr(4'd4, 16'd3);
    wr(4'd5, 16'd3);
    wr(4'd6, 16'h0020);
    wr(4'd7, 16'h0055);
    wr(4'd8, C_EXT | 16'h1000);
    wr(4'd0, 16'd3);
    evtStep();
    peek(4'd4, d);
    chk("R10 compare 1 preloaded", d, 16'h0020);
    peek(4'd5, d);
    chk("R10 compare 2 kept", d, 16'd3);

    // R11: write-one-to-clear and interrupt masking
    wr(4'd9, 16'h000F);
    peek(4'd9, d);
    chk("R11 all cleared", {12'b0, d[3:0]}, 16'h0);
    wr(4'd10, 16'h0001);
    wr(4'd8, C_EXT);
    wr(4'd4, 16'd3);
    wr(4'd0, 16'd3);
    evtStep();
    chk("R11 irq raised", {15'b0, irq}, 16'h1);
    wr(4'd9, 16'h0002);
    chk("R11 other bit no clear", {15'b0, irq}, 16'h1);
    wr(4'd9, 16'h0001);
    chk("R11 irq cleared", {15'b0, irq}, 16'h0);
    wr(4'd10, 16'h0000);
    wr(4'd0, 16'd3);
    evtStep();
    chk("R11 masked irq", {15'b0, irq}, 16'h0);
    peek(4'd9, d);
    chk("R11 status still set", {15'b0, d[0]}, 16'h1);

    // R5: hold snapshot
    wr(4'd8, 16'h0000);
    wr(4'd0, 16'h4321);
    @(negedge clk); holdSnap = 1'b1;
    @(negedge clk); holdSnap = 1'b0;
    wr(4'd0, 16'h1111);
    peek(4'd2, d);
    chk("R5 hold keeps snapshot", d, 16'h4321);

    // R6/R7: directed fill then overflow
    wr(4'd9, 16'h000F);
    wr(4'd0, 16'hAAAA); capPulse();
    wr(4'd0, 16'hBBBB); capPulse();
    wr(4'd0, 16'hCCCC); capPulse();
    peek(4'd9, d);
    chk("R7 overflow sticky and capture bit", {12'b0, d[3:2], 2'b0}, 16'h000C);
    chk("R6 level full", {14'b0, d[5:4]}, 16'h2);
    rd(4'd3, d); chk("R6 oldest first", d, 16'hAAAA);
    rd(4'd3, d); chk("R7 discarded newest", d, 16'hBBBB);
    rd(4'd3, d); chk("R6 empty after drain", d, 16'h0);

    // R6/R7: random captures and pops against a queue model
    wr(4'd9, 16'h000F);
    expOvf = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (($urandom % 3) < 2) begin
        logic [15:0] v;
        v = 16'($urandom);
        wr(4'd0, v);
        capPulse();
        if (q.size() < 2) q.push_back(v);
        else expOvf = 1'b1;
      end else begin
        rd(4'd3, d);
        if (q.size() > 0) begin
          chk("R6 random pop", d, q[0]);
          void'(q.pop_front());
        end else begin
          chk("R6 random empty pop", d, 16'h0);
        end
      end
      peek(4'd9, d);
      chk("R6 random level", {14'b0, d[5:4]}, 16'(q.size()));
    end
    chk("R7 random overflow flag", {15'b0, d[3]}, {15'b0, expOvf});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule